// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a colour lookup table of 256 entries. Each entry has one red, one green and one blue byte. A host fills the table through two 32-bit write registers that sit in a 16-byte window. The first register selects an entry. The second register receives colour bytes, one per write, in red, green, blue order. After the blue byte, the selection moves on to the next entry, so software can load a run of entries with a single select write followed by a stream of data writes.

The display side reads the table through a separate lookup port. An 8-bit entry number is registered on a clock edge, and the 24-bit colour of that entry appears after that edge. Every accepted colour byte also raises a one-cycle change strobe, so the display logic knows to redraw the whole frame. Host reads of the register window are acknowledged and always return zero.

Top module: `pal_loader`

## Requirements
- R1: After reset every entry is black (0,0,0) except entry 255, which is white (255,255,255). Reset also sets the entry selection to 0 and the colour phase to red.
- R2: A write to byte offset 0 loads the entry selection from bits 31:24 of the write data. It also returns the colour phase to red, even when a colour sequence is part-way through.
- R3: A write to byte offset 4 stores bits 31:24 of the write data into one component of the selected entry. Phases red, green and blue store the red, green and blue byte, and the phase then advances to the next colour. Bits 23:0 have no effect.
- R4: A data write in the blue phase increments the entry selection modulo 256, so 255 wraps to 0, and sets the phase back to red.
- R5: A write to any offset other than 0 or 4 leaves the table, the entry selection and the colour phase unchanged.
- R6: `lut_rgb` shows the entry whose number was on `lut_idx` at the previous rising clock edge. The layout is red in bits 23:16, green in 15:8 and blue in 7:0. A component written at that same edge is already visible.
- R7: `pal_changed` is high for exactly the one cycle that follows each accepted data write, and low at all other times.
- R8: `host_rd_ack` is high in the cycle after each cycle in which `host_rd_en` is high. `host_rd_data` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 4 | Byte offset of the write within the window |
| wr_data | input | 32 | Host write data; only the top byte is used |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_ack | output | 1 | Read acknowledge, one cycle after the strobe |
| host_rd_data | output | 32 | Read data, always zero |
| lut_idx | input | 8 | Entry number for the display lookup |
| lut_rgb | output | 24 | Colour of the registered entry number |
| pal_changed | output | 1 | One-cycle strobe after each stored colour byte |

## Verification
Every result of this block is due in the cycle that follows the edge that samples the stimulus:
- a stored byte appears on `lut_rgb` after that edge,
- the lookup port shows a new entry number after its first edge,
- `pal_changed` and `host_rd_ack` rise for exactly that next cycle.

The bench updates its behavioural model of table, selection and phase at each rising edge. It compares all outputs 2 ns after that edge, well before the next input change at the falling edge. Directed sequences for reset values, sequence restarts, selection wrap and ignored offsets are read back through the lookup port one edge after the index is applied.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Colour phase of the data-register sequence; order is behaviour.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } pal_phase_e;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/pal_wr_decode.sv
module pal_wr_decode #(
    parameter int ADDR_W    = 4,
    parameter int OFS_INDEX = 0,
    parameter int OFS_DATA  = 4
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              idx_we,
    output logic              dat_we
);

    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(OFS_DATA);

    always_comb begin
        idx_we = 1'b0;
        dat_we = 1'b0;
        if (wr_valid) begin
            if (wr_addr == SEL_A) begin
                idx_we = 1'b1;
            end else if (wr_addr == DAT_A) begin
                dat_we = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_we,
    input  logic                  dat_we,
    input  logic [IDX_W-1:0]      new_idx,
    output logic [NUM_CH-1:0]     comp_we,
    output logic [IDX_W-1:0]      cur_idx,
    output pal_phase_e            cur_phase,
    output logic                  chg_strobe
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        pal_phase_e       phase;
        logic             chg;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        comp_we  = '0;
        if (idx_we) begin
            st_d.idx   = new_idx;
            st_d.phase = PH_RED;
        end else if (dat_we) begin
            st_d.chg = 1'b1;
            case (st_q.phase)
                PH_RED: begin
                    comp_we[0] = 1'b1;
                    st_d.phase = PH_GRN;
                end
                PH_GRN: begin
                    comp_we[1] = 1'b1;
                    st_d.phase = PH_BLU;
                end
                PH_BLU: begin
                    comp_we[2] = 1'b1;
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + 1'b1;
                end
                default: st_d.phase = PH_RED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, phase: PH_RED, chg: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx    = st_q.idx;
    assign cur_phase  = st_q.phase;
    assign chg_strobe = st_q.chg;

endmodule

// File: rtl/pal_comp_bank.sv
module pal_comp_bank #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [CH_W-1:0]  wbyte,
    input  logic [IDX_W-1:0] raddr,
    output logic [CH_W-1:0]  rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] mem_d [DEPTH];
    logic [CH_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wbyte;
        end
    end

    // Top entry resets to full scale, all others to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i == DEPTH - 1) ? {CH_W{1'b1}} : '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = 8,
    parameter int CH_W      = 8,
    parameter int OFS_INDEX = 0,
    parameter int OFS_DATA  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BUS_W-1:0]         wr_data,
    input  logic                     host_rd_en,
    output logic                     host_rd_ack,
    output logic [BUS_W-1:0]         host_rd_data,
    input  logic [IDX_W-1:0]         lut_idx,
    output logic [NUM_CH*CH_W-1:0]   lut_rgb,
    output logic                     pal_changed
);

    localparam int RGB_W = NUM_CH * CH_W;

    logic              idx_we, dat_we;
    logic [NUM_CH-1:0] comp_we;
    logic [IDX_W-1:0]  seq_idx;
    pal_phase_e        seq_phase;
    logic [CH_W-1:0]   ch_rd [NUM_CH];
    logic              unused_wr_bits;

    // Only the top byte of the bus is meaningful.
    wire [IDX_W-1:0] top_idx  = wr_data[BUS_W-1 -: IDX_W];
    wire [CH_W-1:0]  top_byte = wr_data[BUS_W-1 -: CH_W];
    assign unused_wr_bits = ^wr_data;

    pal_wr_decode #(
        .ADDR_W    (ADDR_W),
        .OFS_INDEX (OFS_INDEX),
        .OFS_DATA  (OFS_DATA)
    ) u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .idx_we   (idx_we),
        .dat_we   (dat_we)
    );

    pal_wr_seq #(
        .IDX_W (IDX_W),
        .CH_W  (CH_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_we     (idx_we),
        .dat_we     (dat_we),
        .new_idx    (top_idx),
        .comp_we    (comp_we),
        .cur_idx    (seq_idx),
        .cur_phase  (seq_phase),
        .chg_strobe (pal_changed)
    );

    // Lookup index and host read acknowledge registers.
    typedef struct packed {
        logic [IDX_W-1:0] look;
        logic             ack;
    } port_t;

    port_t pt_d, pt_q;

    always_comb begin
        pt_d      = pt_q;
        pt_d.look = lut_idx;
        pt_d.ack  = host_rd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
        pal_comp_bank #(
            .IDX_W (IDX_W),
            .CH_W  (CH_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (comp_we[ch]),
            .waddr (seq_idx),
            .wbyte (top_byte),
            .raddr (pt_q.look),
            .rdata (ch_rd[ch])
        );
        assign lut_rgb[RGB_W-1-ch*CH_W -: CH_W] = ch_rd[ch];
    end

    assign host_rd_ack  = pt_q.ack;
    assign host_rd_data = '0;

endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk
    import pal_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = 8,
    parameter int OFS_INDEX = 0,
    parameter int OFS_DATA  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic              host_rd_en,
    input logic              host_rd_ack,
    input logic              pal_changed,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [1:0]        cur_phase
);

    wire sel_wr   = wr_valid && (wr_addr == ADDR_W'(OFS_INDEX));
    wire dat_wr   = wr_valid && (wr_addr == ADDR_W'(OFS_DATA));
    wire other_wr = wr_valid && !sel_wr && !dat_wr;

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (cur_idx == $past(wr_data[BUS_W-1 -: IDX_W])) && (cur_phase == PH_RED));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cur_phase == PH_RED) |=> (cur_phase == PH_GRN) && $stable(cur_idx));

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cur_phase == PH_BLU) |=>
            (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == PH_RED));

    // R5
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(cur_idx) && $stable(cur_phase));

    // R7
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> pal_changed);

    // R7
    chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> !pal_changed);

    // R8
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en |=> host_rd_ack);

    // R8
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> !host_rd_ack);

endmodule

bind pal_loader pal_loader_chk #(
    .BUS_W     (BUS_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .OFS_INDEX (OFS_INDEX),
    .OFS_DATA  (OFS_DATA)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .host_rd_en  (host_rd_en),
    .host_rd_ack (host_rd_ack),
    .pal_changed (pal_changed),
    .cur_idx     (seq_idx),
    .cur_phase   (seq_phase)
);

// File: tb/pal_loader_bench.sv
`timescale 1ns/1ps
module pal_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic        host_rd_ack;
    logic [31:0] host_rd_data;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;
    logic        pal_changed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pal_loader u_pal_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .host_rd_en   (host_rd_en),
        .host_rd_ack  (host_rd_ack),
        .host_rd_data (host_rd_data),
        .lut_idx      (lut_idx),
        .lut_rgb      (lut_rgb),
        .pal_changed  (pal_changed)
    );

    // Behavioural reference model
    byte unsigned m_r [256];
    byte unsigned m_g [256];
    byte unsigned m_b [256];
    int  m_sel, m_ph, m_look;
    bit  m_chg, m_ack, m_live;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_r[i] = (i == 255) ? 8'hFF : 8'h00;
                m_g[i] = m_r[i];
                m_b[i] = m_r[i];
            end
            m_sel = 0; m_ph = 0; m_look = 0; m_chg = 0; m_ack = 0;
            m_live = 1;
        end else begin
            m_chg = 0;
            if (wr_valid && wr_addr == 4'd0) begin
                m_sel = wr_data[31:24];
                m_ph  = 0;
            end else if (wr_valid && wr_addr == 4'd4) begin
                m_chg = 1;
                if (m_ph == 0) m_r[m_sel] = wr_data[31:24];
                else if (m_ph == 1) m_g[m_sel] = wr_data[31:24];
                else m_b[m_sel] = wr_data[31:24];
                if (m_ph == 2) begin
                    m_ph  = 0;
                    m_sel = (m_sel + 1) % 256;
                end else begin
                    m_ph = m_ph + 1;
                end
            end
            m_ack  = host_rd_en;
            m_look = lut_idx;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        if (rst_n && m_live) begin
            #2;
            chk(lut_rgb == {m_r[m_look], m_g[m_look], m_b[m_look]},
                "R6 lookup vs model", {8'h0, lut_rgb},
                {8'h0, m_r[m_look], m_g[m_look], m_b[m_look]});
            chk(pal_changed == m_chg, "R7 change strobe",
                {31'h0, pal_changed}, {31'h0, m_chg});
            chk(host_rd_ack == m_ack && host_rd_data == 32'h0, "R8 host read",
                {host_rd_data[30:0], host_rd_ack}, {31'h0, m_ack});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0; wr_data = '0;
    endtask

    task automatic look(input logic [7:0] i, input logic [23:0] exp,
                        input string tag);
        @(negedge clk);
        lut_idx = i;
        @(posedge clk);
        #2;
        chk(lut_rgb == exp, tag, {8'h0, lut_rgb}, {8'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        look(8'd0,   24'h000000, "R1 entry 0 black");
        look(8'd255, 24'hFFFFFF, "R1 entry 255 white");
        look(8'd128, 24'h000000, "R1 entry 128 black");

        // R1 + R3 selection starts at 0, phase at red
        wr(4'd4, 32'h0900_0000);
        look(8'd0, 24'h090000, "R1 initial selection and phase");

        // R3 full colour with junk low bits
        wr(4'd0, 32'h05FF_FFFF);
        wr(4'd4, 32'h12AB_CDEF);
        wr(4'd4, 32'h3401_0203);
        wr(4'd4, 32'h56FF_00FF);
        look(8'd5, 24'h123456, "R3 entry 5 rgb");

        // R4 next data write lands on following entry red
        wr(4'd4, 32'h7700_0000);
        look(8'd6, 24'h770000, "R4 auto increment");

        // R2 selection write restarts the sequence
        wr(4'd0, 32'h0A00_0000);
        wr(4'd4, 32'h1100_0000);
        wr(4'd0, 32'h1400_0000);
        wr(4'd4, 32'h2200_0000);
        look(8'd10, 24'h110000, "R2 old entry keeps red only");
        look(8'd20, 24'h220000, "R2 phase reset to red");

        // R4 wrap 255 -> 0
        wr(4'd0, 32'hFF00_0000);
        wr(4'd4, 32'h0100_0000);
        wr(4'd4, 32'h0200_0000);
        wr(4'd4, 32'h0300_0000);
        wr(4'd4, 32'h4400_0000);
        look(8'd255, 24'h010203, "R4 entry 255 written");
        look(8'd0,   24'h440000, "R4 wrap to entry 0");

        // R5 other offsets ignored
        wr(4'd0, 32'h1E00_0000);
        wr(4'd4, 32'hAA00_0000);
        wr(4'd8, 32'h2800_0000);
        wr(4'd12, 32'h2900_0000);
        wr(4'd1, 32'h3000_0000);
        wr(4'd4, 32'hBB00_0000);
        wr(4'd4, 32'hCC00_0000);
        look(8'd30, 24'hAABBCC, "R5 ignored offsets keep phase");
        look(8'd40, 24'h000000, "R5 ignored offsets keep selection");

        // R8 host reads
        @(negedge clk); host_rd_en = 1'b1;
        @(negedge clk); host_rd_en = 1'b0;
        chk(host_rd_ack == 1'b1 && host_rd_data == 0, "R8 read ack",
            {31'h0, host_rd_ack}, 32'h1);

        // Random mix compared against the model every cycle (R3 R6 R7)
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            wr_valid   = ($urandom % 3) != 0;
            wr_addr    = 4'(($urandom % 4) * 4);
            wr_data    = $urandom;
            host_rd_en = $urandom % 2;
            lut_idx    = 8'($urandom);
        end
        @(negedge clk);
        wr_valid = 1'b0; host_rd_en = 1'b0;

        // R1 second reset restores contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(8'd5,   24'h000000, "R1 reset clears entry");
        look(8'd255, 24'hFFFFFF, "R1 reset restores white");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule